// File: doc/BRIEF.md
# Dual-Timebase Activity Watchdog

This block is a watchdog that counts down from a 16-bit value that software programs. A one-pulse-per-second tick input drives the count. The count steps either once per tick (seconds timebase) or once per sixty ticks (minutes timebase). A small byte-wide configuration port holds four registers: control, configuration, value low byte and value high byte. Writing either value byte loads the counter at once. A value of zero leaves the watchdog stopped.

While the counter runs, activity from peripherals can restart it with no software kick. The four sources are a game-port read strobe, a remote-control receiver interrupt, a mouse interrupt and a keyboard interrupt, and each one has its own enable bit. The reload does not happen at once. It takes effect a fixed number of system clock cycles after the event.

Expiry happens when the count runs out or when software forces it. On expiry the block sets a sticky status flag. Depending on the configuration, it also fires a keyboard-controller reset pulse, raises a timeout output and drops power-good. An all-zero configuration is a test mode: expiry sets only the flag.

Top module: `evwdog`

## Requirements
- R1: Register select 0 is control, 1 is configuration, 2 is value low byte and 3 is value high byte. Reading control returns the source enables in bits 7:4 and the status flag in bit 0, with bits 3:1 reading 0. The other three registers read back as they were written.
- R2: A write to either value byte loads the counter with the full 16-bit value {high, low} after that write. It also clears the minutes prescaler.
- R3: When configuration bit 7 is 1 (seconds timebase), each tick decrements a nonzero count by one.
- R4: When configuration bit 7 is 0 (minutes timebase), a nonzero count decrements on every MIN_DIV-th tick counted since the last load or reload.
- R5: A count of zero means stopped, and ticks and activity events then have no effect on it. After expiry the count stays at zero until a value byte is written.
- R6: Expiry sets the status flag (control bit 0) and leaves the count at zero. Expiry happens when a tick takes the count from 1 to 0, or when control is written with bit 1 set (force).
- R7: A control write with bit 0 equal to 0 clears the status flag. An expiry in the same cycle takes priority and leaves the flag set.
- R8: Each activity source has an enable bit in control: bit 7 remote-control, bit 6 mouse, bit 5 keyboard, bit 4 game port. An enabled event seen while the count is nonzero reloads the count from the value registers exactly RELOAD_DLY cycles later. Events from disabled sources have no effect.
- R9: If configuration bit 6 is set at expiry, kbc_rst_o is high for exactly RST_LEN cycles, starting at the clock edge of the expiry.
- R10: timeout_o is high while the status flag is set and configuration bit 5 is 1. pg_drop_o is high while the status flag is set and configuration bit 4 is 1.
- R11: With configuration equal to 0 (test mode), expiry sets only the status flag, and kbc_rst_o, timeout_o and pg_drop_o stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse each second |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Read data of the selected register |
| ev_remote_i | input | 1 | Remote-control receiver interrupt event |
| ev_mouse_i | input | 1 | Mouse interrupt event |
| ev_kbd_i | input | 1 | Keyboard interrupt event |
| ev_game_i | input | 1 | Game-port read strobe |
| count_o | output | 16 | Current count |
| kbc_rst_o | output | 1 | Keyboard-controller reset pulse |
| timeout_o | output | 1 | Timeout level output |
| pg_drop_o | output | 1 | Power-good deassert request |

## Verification
A corrupted count shows up on count_o one cycle after the tick, write or reload that caused it. The effect appears only later on the reset outputs, at the wrong expiry tick. A prescaler that skips its clear on load moves the first minutes decrement earlier by up to MIN_DIV ticks, so the bench counts ticks exactly after a mid-minute reload. A reload delay that is off by one cycle is caught at the exact sampled cycle. A stuck status flag shows at once on timeout_o, on pg_drop_o and in the control readback.

// File: rtl/evwdog_pkg.sv
package evwdog_pkg;
  localparam int CNT_W = 16;
  localparam int NSRC  = 4;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_VLO  = 2'd2,
    SEL_VHI  = 2'd3
  } reg_sel_e;

  // control fields
  localparam int CTL_EN_LSB = 4;
  localparam int CTL_FORCE  = 1;
  localparam int CTL_STAT   = 0;
  // configuration fields
  localparam int CFG_SECS   = 7;
  localparam int CFG_KRST   = 6;
  localparam int CFG_TOUT   = 5;
  localparam int CFG_PGOOD  = 4;

  // full value seen after a byte write to one of the value registers
  function automatic logic [CNT_W-1:0] merge_value(input logic [1:0] sel,
                                                   input logic [7:0] wdata,
                                                   input logic [7:0] lo,
                                                   input logic [7:0] hi);
    if (sel == SEL_VLO) return {hi, wdata};
    return {wdata, lo};
  endfunction

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction
endpackage

// File: rtl/evwdog_regs.sv
module evwdog_regs
  import evwdog_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [1:0]         sel_i,
  input  logic [7:0]         wdata_i,
  input  logic               expire_i,
  output logic [NSRC-1:0]    en_o,
  output logic [7:0]         cfg_o,
  output logic [CNT_W-1:0]   value_o,
  output logic               status_o,
  output logic               force_o,
  output logic               load_o,
  output logic [CNT_W-1:0]   load_val_o,
  output logic [7:0]         rdata_o
);
  logic [NSRC-1:0] en_q;
  logic [7:0]      cfg_q, lo_q, hi_q;
  logic            stat_q;
  logic            wr_ctrl, wr_cfg, wr_lo, wr_hi;

  assign wr_ctrl = we_i && (sel_i == SEL_CTRL);
  assign wr_cfg  = we_i && (sel_i == SEL_CFG);
  assign wr_lo   = we_i && (sel_i == SEL_VLO);
  assign wr_hi   = we_i && (sel_i == SEL_VHI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      cfg_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      stat_q <= 1'b0;
    end else begin
      if (wr_ctrl) en_q <= wdata_i[CTL_EN_LSB +: NSRC];
      if (wr_cfg)  cfg_q <= wdata_i;
      if (wr_lo)   lo_q <= wdata_i;
      if (wr_hi)   hi_q <= wdata_i;
      if (expire_i)
        stat_q <= 1'b1;
      else if (wr_ctrl && !wdata_i[CTL_STAT])
        stat_q <= 1'b0;
    end
  end

  assign en_o       = en_q;
  assign cfg_o      = cfg_q;
  assign value_o    = {hi_q, lo_q};
  assign status_o   = stat_q;
  assign force_o    = wr_ctrl && wdata_i[CTL_FORCE];
  assign load_o     = wr_lo || wr_hi;
  assign load_val_o = merge_value(sel_i, wdata_i, lo_q, hi_q);

  always_comb begin
    unique case (sel_i)
      SEL_CTRL: rdata_o = {en_q, 3'b000, stat_q};
      SEL_CFG:  rdata_o = cfg_q;
      SEL_VLO:  rdata_o = lo_q;
      default:  rdata_o = hi_q;
    endcase
  end
endmodule

// File: rtl/evwdog_reload.sv
module evwdog_reload
  import evwdog_pkg::*;
#(
  parameter int RELOAD_DLY = 250000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ev_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            armed_i,
  output logic            reload_o
);
  localparam int DLY_W = $clog2(RELOAD_DLY + 1);
  localparam logic [DLY_W-1:0] DLY_START = DLY_W'(RELOAD_DLY - 1);

  logic [NSRC-1:0] qual;
  logic            hit, pend_q;
  logic [DLY_W-1:0] dcnt_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign qual[g] = ev_i[g] & en_i[g];
  end

  assign hit      = (|qual) && armed_i;
  assign reload_o = pend_q && (dcnt_q == '0) && armed_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      dcnt_q <= '0;
    end else if (pend_q) begin
      if (dcnt_q == '0) pend_q <= 1'b0;
      else              dcnt_q <= dcnt_q - 1'b1;
    end else if (hit) begin
      pend_q <= 1'b1;
      dcnt_q <= DLY_START;
    end
  end
endmodule

// File: rtl/evwdog_countdown.sv
module evwdog_countdown
  import evwdog_pkg::*;
#(
  parameter int MIN_DIV = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             secs_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic             force_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  localparam int PRE_W = (MIN_DIV > 1) ? $clog2(MIN_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(MIN_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic             running, step;

  assign running  = (cnt_q != '0);
  assign step     = tick_i && running && (secs_i || (pre_q == PRE_LAST));
  assign expire_o = force_i || (step && (cnt_q == CNT_W'(1)) && !load_i && !reload_i);
  assign count_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      pre_q <= '0;
    end else if (force_i) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else if (reload_i) begin
      cnt_q <= reload_val_i;
      pre_q <= '0;
    end else if (tick_i && running) begin
      if (step) begin
        cnt_q <= step_down(cnt_q);
        pre_q <= '0;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/evwdog_outputs.sv
module evwdog_outputs
  import evwdog_pkg::*;
#(
  parameter int RST_LEN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire_i,
  input  logic [7:0] cfg_i,
  input  logic       status_i,
  output logic       kbc_rst_o,
  output logic       timeout_o,
  output logic       pg_drop_o
);
  localparam int RW = $clog2(RST_LEN + 1);
  localparam logic [RW-1:0] RST_FULL = RW'(RST_LEN);

  logic          live;
  logic [RW-1:0] rcnt_q;

  assign live = (cfg_i != 8'h00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rcnt_q <= '0;
    else if (expire_i && live && cfg_i[CFG_KRST])
      rcnt_q <= RST_FULL;
    else if (rcnt_q != '0)
      rcnt_q <= rcnt_q - 1'b1;
  end

  assign kbc_rst_o = (rcnt_q != '0);
  assign timeout_o = live && status_i && cfg_i[CFG_TOUT];
  assign pg_drop_o = live && status_i && cfg_i[CFG_PGOOD];
endmodule

// File: rtl/evwdog.sv
module evwdog
  import evwdog_pkg::*;
#(
  parameter int MIN_DIV    = 60,
  parameter int RELOAD_DLY = 250000,
  parameter int RST_LEN    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        cfg_we_i,
  input  logic [1:0]  cfg_sel_i,
  input  logic [7:0]  cfg_wdata_i,
  output logic [7:0]  cfg_rdata_o,
  input  logic        ev_remote_i,
  input  logic        ev_mouse_i,
  input  logic        ev_kbd_i,
  input  logic        ev_game_i,
  output logic [15:0] count_o,
  output logic        kbc_rst_o,
  output logic        timeout_o,
  output logic        pg_drop_o
);
  logic [NSRC-1:0]  en, ev;
  logic [7:0]       cfg;
  logic [CNT_W-1:0] value, load_val, count;
  logic             status, force_evt, load_evt, reload_evt, expire_evt;

  // source order matches the control enable bits 7:4
  assign ev = {ev_remote_i, ev_mouse_i, ev_kbd_i, ev_game_i};

  evwdog_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .sel_i(cfg_sel_i),
    .wdata_i(cfg_wdata_i), .expire_i(expire_evt), .en_o(en), .cfg_o(cfg),
    .value_o(value), .status_o(status), .force_o(force_evt),
    .load_o(load_evt), .load_val_o(load_val), .rdata_o(cfg_rdata_o)
  );

  evwdog_reload #(.RELOAD_DLY(RELOAD_DLY)) u_reload (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .en_i(en),
    .armed_i(count != '0), .reload_o(reload_evt)
  );

  evwdog_countdown #(.MIN_DIV(MIN_DIV)) u_count (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .secs_i(cfg[CFG_SECS]),
    .load_i(load_evt), .load_val_i(load_val), .reload_i(reload_evt),
    .reload_val_i(value), .force_i(force_evt), .count_o(count),
    .expire_o(expire_evt)
  );

  evwdog_outputs #(.RST_LEN(RST_LEN)) u_out (
    .clk(clk), .rst_n(rst_n), .expire_i(expire_evt), .cfg_i(cfg),
    .status_i(status), .kbc_rst_o(kbc_rst_o), .timeout_o(timeout_o),
    .pg_drop_o(pg_drop_o)
  );

  assign count_o = count;
endmodule

// File: rtl/evwdog_chk.sv
module evwdog_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] count,
  input logic        load_evt,
  input logic        reload_evt,
  input logic        expire_evt,
  input logic        status,
  input logic [7:0]  cfg,
  input logic        kbc_rst_o,
  input logic        timeout_o,
  input logic        pg_drop_o
);
  // R6
  expire_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> status);

  // R5
  stopped_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == 16'h0 && !load_evt) |=> (count == 16'h0));

  // R3
  no_count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !reload_evt) |=> (count <= $past(count)));

  // R9
  krst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kbc_rst_o) |-> ($past(expire_evt) && $past(cfg[6])));

  // R11
  test_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == 8'h00) |-> (!timeout_o && !pg_drop_o));

  // R10
  outputs_need_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o || pg_drop_o) |-> status);
endmodule

bind evwdog evwdog_chk chk_i (
  .clk(clk), .rst_n(rst_n), .count(count), .load_evt(load_evt),
  .reload_evt(reload_evt), .expire_evt(expire_evt), .status(status),
  .cfg(cfg), .kbc_rst_o(kbc_rst_o), .timeout_o(timeout_o), .pg_drop_o(pg_drop_o)
);

// File: tb/evwdog_tb_top.sv
module evwdog_tb_top;
  localparam int MIN_DIV = 60;
  localparam int DLY     = 8;
  localparam int RLEN    = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [3:0]  ev = 4'h0;  // [3]=remote [2]=mouse [1]=kbd [0]=game
  logic [15:0] count;
  logic        krst, tout, pgd;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  evwdog #(.MIN_DIV(MIN_DIV), .RELOAD_DLY(DLY), .RST_LEN(RLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .cfg_we_i(we), .cfg_sel_i(sel),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .ev_remote_i(ev[3]),
    .ev_mouse_i(ev[2]), .ev_kbd_i(ev[1]), .ev_game_i(ev[0]), .count_o(count),
    .kbc_rst_o(krst), .timeout_o(tout), .pg_drop_o(pgd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); we = 1'b1; sel = s; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); sel = s; #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic pulse_ev(input int idx);
    @(negedge clk); ev = 4'h0; ev[idx] = 1'b1;
    @(negedge clk); ev = 4'h0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // reset state
    check("R1 reset count", count, 0);
    check("R6 reset status", {krst, tout, pgd}, 0);
    rd(2'd0, r); check("R1 reset ctrl", r, 0);

    // R1 readback
    wr(2'd1, 8'h5A); rd(2'd1, r); check("R1 cfg readback", r, 8'h5A);
    wr(2'd0, 8'hF0); rd(2'd0, r); check("R1 ctrl readback", r, 8'hF0);
    wr(2'd3, 8'h12); wr(2'd2, 8'h34);
    rd(2'd3, r); check("R1 hi readback", r, 8'h12);
    rd(2'd2, r); check("R1 lo readback", r, 8'h34);
    check("R2 full load", count, 16'h1234);
    wr(2'd3, 8'h00); check("R2 hi write loads", count, 16'h0034);

    // R3 seconds sweep, timeout output enabled
    wr(2'd1, 8'hA0);
    for (int n = 1; n <= 6; n++) begin
      wr(2'd0, 8'h00);
      wr(2'd2, 8'(n));
      ticks(n - 1);
      check("R3 count before last tick", count, 1);
      check("R6 no early expiry", tout, 0);
      ticks(1);
      check("R6 count at expiry", count, 0);
      rd(2'd0, r); check("R6 status set", r[0], 1);
      check("R10 timeout_o", {tout, pgd}, 2'b10);
      ticks(2);
      check("R5 stays zero", count, 0);
    end

    // R7 clear status; writing bit0=1 keeps it
    wr(2'd0, 8'h01); rd(2'd0, r); check("R7 keep status", r[0], 1);
    wr(2'd0, 8'h00); rd(2'd0, r); check("R7 clear status", r[0], 0);
    check("R10 timeout drops", tout, 0);

    // R5 events after expiry / zero value ignored
    wr(2'd0, 8'hF0);
    pulse_ev(2); idle(DLY + 2);
    check("R5 event ignored when stopped", count, 0);
    wr(2'd2, 8'h00); ticks(3);
    rd(2'd0, r); check("R5 zero value no expiry", r[0], 0);

    // R4 minutes timebase
    wr(2'd1, 8'h30);  // minutes, timeout + power-good
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h02);
    ticks(MIN_DIV - 1); check("R4 no step before divider", count, 2);
    ticks(1);           check("R4 first minute step", count, 1);
    ticks(MIN_DIV - 1); check("R4 hold second minute", count, 1);
    ticks(1);           check("R4 expiry", count, 0);
    check("R10 both outputs", {tout, pgd}, 2'b11);

    // R2 prescaler cleared by load
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h03);
    ticks(30);
    wr(2'd2, 8'h03);
    ticks(MIN_DIV - 1); check("R2 prescaler cleared", count, 3);
    ticks(1);           check("R2 step after full minute", count, 2);

    // R8 reload per source, enabled vs disabled
    wr(2'd1, 8'h80);
    for (int i = 0; i < 4; i++) begin
      wr(2'd2, 8'h0A);
      ticks(3);
      check("R8 pre-event count", count, 7);
      wr(2'd0, 8'(1 << (4 + i)));
      pulse_ev((i + 1) % 4);
      idle(DLY + 2);
      check("R8 disabled source ignored", count, 7);
      pulse_ev(i);
      idle(DLY - 1);
      check("R8 no reload before delay", count, 7);
      idle(1);
      check("R8 reload after delay", count, 10);
    end

    // R9 reset pulse via force, all outputs enabled
    wr(2'd1, 8'hF0);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h05);
    wr(2'd0, 8'h02);
    check("R6 force zeroes count", count, 0);
    rd(2'd0, r); check("R6 force sets status", r[0], 1);
    check("R9 pulse start", krst, 1);
    // rd took one negedge: sample point is RLEN-1 edges in
    idle(RLEN - 2); check("R9 pulse last cycle", krst, 1);
    idle(1);        check("R9 pulse end", krst, 0);

    // R9 no pulse when bit 6 clear
    wr(2'd1, 8'hB0);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h01);
    ticks(1);
    check("R9 no pulse without enable", krst, 0);
    check("R10 outputs with bits 5,4", {tout, pgd}, 2'b11);

    // R11 test mode
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h02);
    rd(2'd0, r); check("R11 status in test mode", r[0], 1);
    check("R11 outputs quiet", {krst, tout, pgd}, 0);
    idle(RLEN + 1);
    check("R11 still quiet", {krst, tout, pgd}, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule